// File: doc/BRIEF.md
# SMBus host byte-read controller

This block is a two-wire bus host that a processor drives through a small byte-wide register file. Software loads a 7-bit target address, a command code and a control word whose start bit launches a read-byte-data exchange. The controller then runs the whole exchange on the bus: it addresses the target for a write, sends the command code, turns the bus round with a repeated START, reads one byte, refuses further data and releases the bus with STOP.

The received byte lands in the data register. Completion or failure is reported by sticky flags in the status register, which software clears by writing ones. A busy bit covers the whole exchange, and software polls until busy is low and a flag is up.

Both bus lines are open-drain. The block only ever pulls a line low or lets it float. The bus clock comes from the system clock through a parameterised divider. With the default divider and a 50 MHz clock, the bus clock runs at 100 kHz.

Top module: `smb_rdbyte_host`

## Requirements
- R1: Registers sit at byte offsets 0 (status), 2 (control), 3 (command), 4 (target address) and 5 (data), and any other offset reads 0. Every register resets to 0. Control bit 6 (start) always reads back 0. Status bits 3 and 4 read 0.
- R2: Status bit 0 (busy) reads 1 from the clock edge that accepts a valid start until the edge that ends the exchange.
- R3: Status bits 1 to 4 are cleared by writing 1 to them, and a 0 leaves them unchanged. If hardware sets a flag in the same cycle as a clear write to that flag, the flag stays set.
- R4: When an exchange succeeds, the block sets status bit 1 (done) in the same edge where busy drops, and the received byte is in the data register.
- R5: If the target fails to acknowledge the write address, the command or the read address, the block sets status bit 2 (error) and still ends with STOP. It sends no further byte, and the data register keeps its old value.
- R6: The bus order is START, then {addr[7:1],0}, then the command byte, then a repeated START, then {addr[7:1],1}, then one byte read MSB first. The master answers the read byte with NACK and then sends STOP. Bytes go out MSB first. SDA changes only while SCL is low, except for the START and STOP conditions.
- R7: A start with control bits 4:2 not equal to 2 sets the error flag at the accepting edge. Busy stays 0 and the bus lines do not move.
- R8: A control write while busy is 1 is ignored entirely. The stored control value does not change and the running exchange continues.
- R9: During an exchange the SCL period is 4*CLK_DIV system clocks. The outputs are pull-low enables only, and both are 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the offset on reg_addr (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
A hardware flag set and a software write-one-to-clear can land on the same edge. This happens at the end of an exchange, when done rises at the same moment software clears it, together with a stale error flag left from an earlier rejected start. The bench first measures how many cycles a successful exchange takes. It then launches an identical exchange and times a status write of 0x06 so that it is sampled on the completion edge. The expected outcome is status 0x02: done survives its own clear, and the stale error bit is removed.

// File: rtl/smb_rdbyte_host.sv
module smb_rdbyte_host #(
  parameter int CLK_DIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTL  = 3'd2;
  localparam logic [2:0] A_CMD  = 3'd3;
  localparam logic [2:0] A_TGT  = 3'd4;
  localparam logic [2:0] A_DAT  = 3'd5;
  localparam logic [2:0] PROTO_RD_BYTE = 3'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDRW, S_CMD, S_RSTART, S_ADDRR, S_READ, S_STOP
  } seq_t;

  seq_t          st;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh, rx;
  logic          fail, sda_low;
  logic [DW-1:0] div_cnt;
  logic [7:0]    ctl_q, cmd_q, tgt_q, dat_q;
  logic [2:1]    flg;

  logic busy, tick, byte_st, ack_st, last_bit, tx_bit;
  logic wr_ctl, stat_wr, go_req, go_ok, go_bad, finish;

  assign busy     = (st != S_IDLE);
  assign tick     = busy && (div_cnt == DIV_LAST);
  assign ack_st   = (st == S_ADDRW) || (st == S_CMD) || (st == S_ADDRR);
  assign byte_st  = ack_st || (st == S_READ);
  assign last_bit = (bitn == 4'd8);
  assign tx_bit   = (st == S_READ) || last_bit || sh[7];
  assign wr_ctl   = reg_wr && (reg_addr == A_CTL);
  assign stat_wr  = reg_wr && (reg_addr == A_STAT);
  assign go_req   = wr_ctl && reg_wdata[6] && !busy;
  assign go_ok    = go_req && (reg_wdata[4:2] == PROTO_RD_BYTE);
  assign go_bad   = go_req && (reg_wdata[4:2] != PROTO_RD_BYTE);
  assign finish   = tick && (ph == 2'd3) && (st == S_STOP);

  assign scl_oe = busy && (st != S_START) && !ph[1];
  assign sda_oe = sda_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_cnt <= '0;
    else if (!busy || tick)    div_cnt <= '0;
    else                       div_cnt <= div_cnt + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= 2'd0;
      bitn    <= 4'd0;
      sh      <= 8'd0;
      rx      <= 8'd0;
      fail    <= 1'b0;
      sda_low <= 1'b0;
    end else if (go_ok) begin
      st      <= S_START;
      ph      <= 2'd0;
      bitn    <= 4'd0;
      fail    <= 1'b0;
      sda_low <= 1'b0;
    end else if (tick) begin
      ph <= ph + 2'd1;
      case (ph)
        2'd0: begin
          if (st == S_STOP)                          sda_low <= 1'b1;
          else if (st == S_START || st == S_RSTART)  sda_low <= 1'b0;
          else                                       sda_low <= !tx_bit;
        end
        2'd2: begin
          if (st == S_START || st == S_RSTART) sda_low <= 1'b1;
          else if (st == S_STOP)               sda_low <= 1'b0;
          if (st == S_READ && !last_bit) rx <= {rx[6:0], sda_in};
          if (ack_st && last_bit && sda_in) fail <= 1'b1;
        end
        2'd3: begin
          case (st)
            S_START: begin
              st   <= S_ADDRW;
              bitn <= 4'd0;
              sh   <= {tgt_q[7:1], 1'b0};
            end
            S_RSTART: begin
              st   <= S_ADDRR;
              bitn <= 4'd0;
              sh   <= {tgt_q[7:1], 1'b1};
            end
            S_STOP: st <= S_IDLE;
            S_IDLE: st <= S_IDLE;
            default: begin
              if (!last_bit) begin
                bitn <= bitn + 4'd1;
                sh   <= {sh[6:0], 1'b0};
              end else begin
                bitn <= 4'd0;
                case (st)
                  S_ADDRW: begin
                    st <= fail ? S_STOP : S_CMD;
                    sh <= cmd_q;
                  end
                  S_CMD:   st <= fail ? S_STOP : S_RSTART;
                  S_ADDRR: st <= fail ? S_STOP : S_READ;
                  default: st <= S_STOP;
                endcase
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 8'd0;
      cmd_q <= 8'd0;
      tgt_q <= 8'd0;
      dat_q <= 8'd0;
      flg   <= 2'b00;
    end else begin
      if (wr_ctl && !busy)                  ctl_q <= reg_wdata & 8'hBF;
      if (reg_wr && reg_addr == A_CMD)      cmd_q <= reg_wdata;
      if (reg_wr && reg_addr == A_TGT)      tgt_q <= reg_wdata;
      if (finish && !fail)                  dat_q <= rx;
      else if (reg_wr && reg_addr == A_DAT) dat_q <= reg_wdata;
      if (stat_wr)                          flg <= flg & ~reg_wdata[2:1];
      if (finish && !fail)                  flg[1] <= 1'b1;
      if ((finish && fail) || go_bad)       flg[2] <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {5'b00000, flg, busy};
      A_CTL:   reg_rdata = ctl_q;
      A_CMD:   reg_rdata = cmd_q;
      A_TGT:   reg_rdata = tgt_q;
      A_DAT:   reg_rdata = dat_q;
      default: reg_rdata = 8'd0;
    endcase
  end

  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_end_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (flg[1] || flg[2]));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[1]) |-> !busy);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[1] && !(finish && !fail)) |=> !flg[1]);

  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctl) |=> ($stable(ctl_q) && busy));

  p_bad_proto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_bad |=> (!busy && flg[2] && !scl_oe && !sda_oe));

  p_sda_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_st && $past(byte_st) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

endmodule

// File: tb/smb_rdbyte_host_bench.sv
`timescale 1ns/1ps
module smb_rdbyte_host_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe;

  logic       s_drv = 1'b0;
  logic       pscl = 1'b1, psda = 1'b1;
  logic       tx = 1'b0, rd_pend = 1'b0, m_nack = 1'b0;
  logic [7:0] sreg = 8'd0, cmd_seen = 8'd0, aw_seen = 8'd0, ar_seen = 8'd0;
  int         cnt = 0, bidx = 0, starts = 0, stops = 0;
  logic [7:0] rd_byte = 8'd0;
  logic [6:0] dev = 7'd0;
  logic [1:0] nsel = 2'd0;

  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | s_drv);

  int checks = 0, fails = 0;

  smb_rdbyte_host #(.CLK_DIV(DIV)) u_smb_rdbyte_host (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
  );

  always #10 clk = ~clk;

  always @(scl_w or sda_w) begin
    if (scl_w !== pscl) begin
      if (scl_w === 1'b1) begin
        if (tx) begin
          if (cnt == 8) m_nack = sda_w;
        end else if (cnt < 8) sreg = {sreg[6:0], sda_w};
        cnt = cnt + 1;
      end else if (scl_w === 1'b0) begin
        if (cnt == 9) begin
          s_drv = 1'b0; cnt = 0; bidx = bidx + 1;
          if (rd_pend) begin tx = 1'b1; rd_pend = 1'b0; s_drv = ~rd_byte[7]; end
          else tx = 1'b0;
        end else if (tx) begin
          s_drv = (cnt < 8) ? ~rd_byte[7-cnt] : 1'b0;
        end else if (cnt == 8) begin
          logic ack;
          ack = 1'b0;
          if (bidx == 0 && sreg[7:1] == dev) begin
            if (!sreg[0]) begin aw_seen = sreg; ack = (nsel != 2'd1); end
            else begin ar_seen = sreg; ack = (nsel != 2'd3); rd_pend = ack; end
          end else if (bidx == 1) begin
            cmd_seen = sreg; ack = (nsel != 2'd2);
          end
          s_drv = ack;
        end
      end
    end else if (sda_w !== psda && scl_w === 1'b1) begin
      if (sda_w === 1'b0) begin
        starts = starts + 1; cnt = 0; bidx = 0; tx = 1'b0; rd_pend = 1'b0; s_drv = 1'b0;
      end else stops = stops + 1;
    end
    pscl = scl_w;
    psda = sda_w;
  end

  logic mon_en = 1'b0;
  logic prev_scl = 1'b0, have_rise = 1'b0;
  int   cyc = 0, last_rise = 0, pmin = 0, pmax = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!mon_en) begin
      have_rise = 1'b0; pmin = 1000000; pmax = 0;
    end else if (scl_oe && !prev_scl) begin
      if (have_rise) begin
        if (cyc - last_rise < pmin) pmin = cyc - last_rise;
        if (cyc - last_rise > pmax) pmax = cyc - last_rise;
      end
      have_rise = 1'b1; last_rise = cyc;
    end
    prev_scl = scl_oe;
  end

  // stimulus {dev, cmd, slave byte, nack select, expected status, expected data}
  localparam logic [40:0] VEC [7] = '{
    {7'h50, 8'h00, 8'hA5, 2'd0, 8'h02, 8'hA5},
    {7'h51, 8'h7F, 8'h3C, 2'd0, 8'h02, 8'h3C},
    {7'h2A, 8'hFF, 8'h00, 2'd0, 8'h02, 8'h00},
    {7'h7F, 8'h80, 8'hFF, 2'd0, 8'h02, 8'hFF},
    {7'h50, 8'h12, 8'h99, 2'd1, 8'h04, 8'h00},
    {7'h50, 8'h34, 8'h99, 2'd2, 8'h04, 8'h00},
    {7'h50, 8'h56, 8'h99, 2'd3, 8'h04, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic wait_done(output int m);
    logic [7:0] s;
    int k;
    k = 1;
    m = 0;
    while (m == 0) begin
      @(negedge clk);
      k = k + 1;
      rd(3'd0, s);
      if (!s[0] && s[7:1] != 7'd0) m = k;
      else if (k > 20000) begin
        chk("R2 completion timeout", 32'd0, 32'd1);
        m = k;
      end
    end
  endtask

  task automatic load(input logic [6:0] d, input logic [7:0] c);
    wr(3'd4, {d, 1'b1});
    wr(3'd3, c);
    wr(3'd5, 8'h00);
  endtask

  initial begin
    #4_000_000;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int m, m2, s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and map
    rd(3'd0, r); chk("R1 status reset", r, 8'h00);
    rd(3'd2, r); chk("R1 control reset", r, 8'h00);
    rd(3'd5, r); chk("R1 data reset", r, 8'h00);
    chk("R9 lines released after reset", {scl_oe, sda_oe}, 2'b00);
    wr(3'd3, 8'h5A); rd(3'd3, r); chk("R1 command readback", r, 8'h5A);
    wr(3'd4, 8'hA1); rd(3'd4, r); chk("R1 target readback", r, 8'hA1);
    wr(3'd5, 8'h33); rd(3'd5, r); chk("R1 data readback", r, 8'h33);
    wr(3'd2, 8'h88); rd(3'd2, r); chk("R1 control readback no start", r, 8'h88);
    rd(3'd0, r); chk("R2 no busy without start", r, 8'h00);
    rd(3'd1, r); chk("R1 unmapped offset 1", r, 8'h00);
    rd(3'd7, r); chk("R1 unmapped offset 7", r, 8'h00);

    // vector table walk: R4 R5 R6
    for (int i = 0; i < 7; i++) begin
      logic [40:0] v;
      v = VEC[i];
      dev = v[40:34]; nsel = v[17:16]; rd_byte = v[25:18];
      wr(3'd0, 8'h1E);
      load(v[40:34], v[33:26]);
      s0 = starts; p0 = stops;
      mon_en = (i == 0);
      wr(3'd2, 8'h48);
      rd(3'd0, r); chk("R2 busy after start", r[0], 1'b1);
      rd(3'd2, r); chk("R1 start bit reads zero", r, 8'h08);
      wait_done(m);
      mon_en = 1'b0;
      rd(3'd0, r); chk(v[17:16] == 2'd0 ? "R4 done status" : "R5 error status", r, v[15:8]);
      rd(3'd5, r); chk(v[17:16] == 2'd0 ? "R4 data captured" : "R5 data kept", r, v[7:0]);
      chk("R5 R6 stop count", stops - p0, 1);
      chk("R6 start count", starts - s0, (v[17:16] == 2'd1 || v[17:16] == 2'd2) ? 1 : 2);
      if (v[17:16] == 2'd0) begin
        chk("R6 write address byte", aw_seen, {v[40:34], 1'b0});
        chk("R6 command byte", cmd_seen, v[33:26]);
        chk("R6 read address byte", ar_seen, {v[40:34], 1'b1});
        chk("R6 master nack", m_nack, 1'b1);
      end
      if (i == 0) begin
        chk("R9 scl period min", pmin, 4 * DIV);
        chk("R9 scl period max", pmax, 4 * DIV);
      end
      chk("R9 lines released when done", {scl_oe, sda_oe}, 2'b00);
    end

    // R7 bad protocol
    wr(3'd0, 8'h1E);
    s0 = starts;
    wr(3'd2, 8'h44);
    rd(3'd0, r); chk("R7 error no busy", r, 8'h04);
    begin
      int moved;
      moved = 0;
      repeat (40) begin @(negedge clk); if (scl_oe || sda_oe) moved = moved + 1; end
      chk("R7 no bus activity", moved, 0);
    end
    chk("R7 no start seen", starts - s0, 0);
    rd(3'd2, r); chk("R1 R7 control stored", r, 8'h04);

    // R8 control write while busy
    dev = 7'h33; nsel = 2'd0; rd_byte = 8'h6E;
    wr(3'd0, 8'h1E);
    load(7'h33, 8'h21);
    s0 = starts;
    wr(3'd2, 8'h48);
    wr(3'd2, 8'h4C);
    rd(3'd2, r); chk("R8 control unchanged", r, 8'h08);
    rd(3'd0, r); chk("R8 still busy", r[0], 1'b1);
    wait_done(m);
    rd(3'd0, r); chk("R8 exchange completes", r, 8'h02);
    rd(3'd5, r); chk("R8 data", r, 8'h6E);
    chk("R8 single exchange", starts - s0, 2);

    // R3 clear individual flags
    wr(3'd2, 8'h44);
    rd(3'd0, r); chk("R3 both flags", r, 8'h06);
    wr(3'd0, 8'h04);
    rd(3'd0, r); chk("R3 clear error only", r, 8'h02);
    wr(3'd0, 8'h00);
    rd(3'd0, r); chk("R3 zero write keeps", r, 8'h02);
    wr(3'd0, 8'h1E);
    rd(3'd0, r); chk("R3 clear all", r, 8'h00);

    // R3 set versus clear on the completion edge
    dev = 7'h50; nsel = 2'd0; rd_byte = 8'hC3;
    wr(3'd2, 8'h44);
    load(7'h50, 8'h0F);
    wr(3'd2, 8'h48);
    wait_done(m);
    rd(3'd0, r); chk("R3 stale error kept", r, 8'h06);
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h48);
    repeat (m - 2) @(negedge clk);
    wr(3'd0, 8'h06);
    rd(3'd0, r); chk("R3 set wins on completion edge", r, 8'h02);
    wait_done(m2);
    chk("R3 exchange length repeatable", m2, 2);
    rd(3'd5, r); chk("R4 data after collision", r, 8'hC3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule